// File: doc/BRIEF.md
# Stack Sequencer for an 8-bit CPU

This block runs every stack-related memory sequence of a small 8-bit processor that has a 16-bit address space. It owns the stack pointer and the program counter. It drives a byte-wide synchronous memory port one access per clock. It carries out:

- byte and word pushes and pulls;
- subroutine call and return, both absolute and PC-relative;
- a software-interrupt entry that saves the user registers and vectors through a fixed address.

It also performs the register-only moves between the stack pointer and an index register, and loads of the stack pointer or program counter.

The instruction decoder asserts `start` together with an operation code and the operand values for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse. Pushes decrement the pointer after each write, and pulls increment it before each read. A word goes out low byte first and comes back high byte first, so any pushed word or return address is recovered in its original form.

Top module: `stk_call_seq`

## Requirements
- R1: The 4-bit `op` codes are: 0 no-op, 1 byte push, 2 byte pull, 3 word push, 4 word pull, 5 call, 6 relative call, 7 return, 8 software interrupt, 9 SP to index, 10 index to SP, 11 load SP, 12 load PC. `start` is taken only while `busy` is low. `busy` stays high from the accepting edge until `done`, and a `start` seen while busy has no effect.
- R2: A byte push (1) writes `push_byte` at the address held in SP and then lowers SP by one.
- R3: A byte pull (2) first raises SP by one, then reads the byte at that new address and presents it on `pull_byte`.
- R4: A word push (3) writes `imm[7:0]` at SP, then `imm[15:8]` at SP-1, leaving SP two lower.
- R5: A word pull (4) reads the high byte at SP+1 and the low byte at SP+2, and presents {high,low} on `pull_word`; SP ends two higher.
- R6: Register-only operations: code 9 puts SP+1 on `xfer_word`; code 10 sets SP to `idx_x`-1; code 11 sets SP to `imm`; code 12 sets PC to `imm`.
- R7: A call (5) pushes the current PC (low byte at SP, high byte at SP-1) and then sets PC to `imm`.
- R8: A relative call (6) pushes PC+2 in the same byte order and then sets PC to PC+2 plus the sign-extended `disp`.
- R9: A return (7) pulls the high byte, then the low byte, into PC.
- R10: A software interrupt (8) pushes, from SP downward: PC low, PC high, `idx_y` low, `idx_y` high, `idx_x` low, `idx_x` high, `acc_a`, `acc_b`, `ccr_in`. It then reads the new PC high byte at $FFF6 and low byte at $FFF7. It sets `ccr_out` to `ccr_in` with bit 4 (interrupt mask) forced to 1, and it runs even when `ccr_in` bit 4 is already set.
- R11: All SP and PC arithmetic wraps modulo 65536.
- R12: There is one memory access per clock, and read data returns on `mem_rdata` in the cycle after its address. `done` is a single-cycle pulse N edges after the accepting edge. N is 0 for register-only operations, the number of bytes written for pushes and calls, bytes read + 1 for pulls and return, and 12 for the software interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation on `op` |
| op | input | 4 | Operation code |
| imm | input | 16 | Word operand: push value, target, new SP or PC |
| disp | input | 8 | Signed displacement for relative call |
| push_byte | input | 8 | Byte to push |
| idx_x | input | 16 | First index register value |
| idx_y | input | 16 | Second index register value |
| acc_a | input | 8 | Accumulator A value |
| acc_b | input | 8 | Accumulator B value |
| ccr_in | input | 8 | Condition code value |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |
| pull_byte | output | 8 | Result of a byte pull |
| pull_word | output | 16 | Result of a word pull |
| xfer_word | output | 16 | SP+1 for an index register |
| ccr_out | output | 8 | Condition codes after interrupt entry |

## Verification
The bench builds the block with its defaults: an 8-bit data byte, a 16-bit address, the vector at $FFF6 and the mask in bit 4. With these values a single word push from SP=$0000 crosses the top of the address map, so the modulo-65536 wrap of R11 is reached in two operations. The full nine-byte interrupt frame and a two-byte vector fetch also fit in a short run. The stack areas and the vector were chosen so that the bench memory, which decodes only the low eight address bits, never aliases two live bytes. Every write address and byte is predicted into a scoreboard queue before the operation starts.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int OPW       = 4;
  localparam int SWI_BYTES = 9;

  typedef enum logic [OPW-1:0] {
    OP_NOP    = 4'd0,
    OP_PUSH_B = 4'd1,
    OP_PULL_B = 4'd2,
    OP_PUSH_W = 4'd3,
    OP_PULL_W = 4'd4,
    OP_CALL   = 4'd5,
    OP_BCALL  = 4'd6,
    OP_RET    = 4'd7,
    OP_SWI    = 4'd8,
    OP_SP2IDX = 4'd9,
    OP_IDX2SP = 4'd10,
    OP_LDSP   = 4'd11,
    OP_JUMP   = 4'd12
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_VEC,
    ST_CAP
  } stk_state_e;

endpackage

// File: rtl/stk_wr_queue.sv
// Shift-out byte queue: loaded in one cycle, drained one byte per pop.
module stk_wr_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 9,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [CW-1:0]             load_cnt,
  input  logic [DEPTH-1:0][DW-1:0]  load_bytes,
  input  logic                      pop,
  output logic [DW-1:0]             head,
  output logic                      last
);

  logic [DW-1:0] slot_q [DEPTH];
  logic [DW-1:0] shift_nxt [DEPTH];
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == DEPTH - 1) begin : g_tail
      assign shift_nxt[g] = '0;
    end else begin : g_body
      assign shift_nxt[g] = slot_q[g+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      cnt_q <= '0;
    end else if (load) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= load_bytes[i];
      cnt_q <= load_cnt;
    end else if (pop) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= shift_nxt[i];
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign head = slot_q[0];
  assign last = (cnt_q == CW'(1));

  a_r12_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt_q != '0));

  a_r12_load_when_empty: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt_q == '0) && !pop);

endmodule

// File: rtl/stk_ptr.sv
// Stack pointer register with load, pre/post step, modulo 2^AW.
module stk_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp
);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (load) sp_q <= load_val;
    else if (inc)  sp_q <= sp_q + AW'(1);
    else if (dec)  sp_q <= sp_q - AW'(1);
  end

  assign sp = sp_q;

  a_r12_single_update: assert property (@(posedge clk) disable iff (rst)
    $countones({load, inc, dec}) <= 1);

  a_r2_dec_step: assert property (@(posedge clk) disable iff (rst)
    dec |=> (sp_q == AW'($past(sp_q) - AW'(1))));

  a_r3_inc_step: assert property (@(posedge clk) disable iff (rst)
    inc |=> (sp_q == AW'($past(sp_q) + AW'(1))));

endmodule

// File: rtl/stk_rd_collect.sv
// Holds the previous read byte so a word can be formed with the current one.
module stk_rd_collect #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic [DW-1:0]   rdata,
  output logic [2*DW-1:0] word
);

  logic [DW-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst)      prev_q <= '0;
    else if (vld) prev_q <= rdata;
  end

  assign word = {prev_q, rdata};

endmodule

// File: rtl/stk_call_seq.sv
module stk_call_seq
  import stk_pkg::*;
#(
  parameter int              DW       = 8,
  parameter logic [2*DW-1:0] VEC_ADDR = 16'hFFF6,
  parameter int              MASK_BIT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OPW-1:0]  op,
  input  logic [2*DW-1:0] imm,
  input  logic [DW-1:0]   disp,
  input  logic [DW-1:0]   push_byte,
  input  logic [2*DW-1:0] idx_x,
  input  logic [2*DW-1:0] idx_y,
  input  logic [DW-1:0]   acc_a,
  input  logic [DW-1:0]   acc_b,
  input  logic [DW-1:0]   ccr_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DW-1:0]   mem_wdata,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] sp,
  output logic [2*DW-1:0] pc,
  output logic [DW-1:0]   pull_byte,
  output logic [2*DW-1:0] pull_word,
  output logic [2*DW-1:0] xfer_word,
  output logic [DW-1:0]   ccr_out
);

  localparam int            AW       = 2 * DW;
  localparam int            QCW      = $clog2(SWI_BYTES + 1);
  localparam logic [DW-1:0] MASK_VEC = DW'(1) << MASK_BIT;

  stk_state_e    st_q;
  stk_op_e       op_q;
  stk_op_e       op_in;
  logic [1:0]    rd_left_q;
  logic          vec_idx_q;
  logic [AW-1:0] pc_q, pc_tgt_q;
  logic [DW-1:0] ccr_snap_q, ccr_q;
  logic [DW-1:0] pull_byte_q;
  logic [AW-1:0] pull_word_q, xfer_q;
  logic          done_q, rd_vld_q;

  logic          accept;
  logic [AW-1:0] ret_addr, disp_ext;
  logic [SWI_BYTES-1:0][DW-1:0] q_bytes;
  logic [QCW-1:0] q_cnt;
  logic          q_load, q_pop, q_last;
  logic [DW-1:0] q_head;

  logic          sp_load, sp_inc, sp_dec;
  logic [AW-1:0] sp_val, sp_w;
  logic [AW-1:0] rd_word;

  assign op_in    = stk_op_e'(op);
  assign accept   = start && (st_q == ST_IDLE);
  assign ret_addr = pc_q + AW'(2);
  assign disp_ext = {{DW{disp[DW-1]}}, disp};

  // Bytes to write, index 0 goes out first (at the current SP).
  always_comb begin
    q_bytes = '0;
    q_cnt   = '0;
    unique case (op_in)
      OP_PUSH_B: begin
        q_bytes[0] = push_byte;
        q_cnt      = QCW'(1);
      end
      OP_PUSH_W: begin
        q_bytes[0] = imm[DW-1:0];
        q_bytes[1] = imm[AW-1:DW];
        q_cnt      = QCW'(2);
      end
      OP_CALL: begin
        q_bytes[0] = pc_q[DW-1:0];
        q_bytes[1] = pc_q[AW-1:DW];
        q_cnt      = QCW'(2);
      end
      OP_BCALL: begin
        q_bytes[0] = ret_addr[DW-1:0];
        q_bytes[1] = ret_addr[AW-1:DW];
        q_cnt      = QCW'(2);
      end
      OP_SWI: begin
        q_bytes[0] = pc_q[DW-1:0];
        q_bytes[1] = pc_q[AW-1:DW];
        q_bytes[2] = idx_y[DW-1:0];
        q_bytes[3] = idx_y[AW-1:DW];
        q_bytes[4] = idx_x[DW-1:0];
        q_bytes[5] = idx_x[AW-1:DW];
        q_bytes[6] = acc_a;
        q_bytes[7] = acc_b;
        q_bytes[8] = ccr_in;
        q_cnt      = QCW'(SWI_BYTES);
      end
      default: ;
    endcase
  end

  assign q_load = accept && (q_cnt != '0);
  assign q_pop  = (st_q == ST_WR);

  stk_wr_queue #(.DW(DW), .DEPTH(SWI_BYTES)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .load       (q_load),
    .load_cnt   (q_cnt),
    .load_bytes (q_bytes),
    .pop        (q_pop),
    .head       (q_head),
    .last       (q_last)
  );

  // Stack pointer: post-decrement on write, pre-increment on read.
  assign sp_dec  = (st_q == ST_WR);
  assign sp_inc  = (st_q == ST_RD);
  assign sp_load = accept && ((op_in == OP_IDX2SP) || (op_in == OP_LDSP));
  assign sp_val  = (op_in == OP_IDX2SP) ? (idx_x - AW'(1)) : imm;

  stk_ptr #(.AW(AW)) u_sp (
    .clk      (clk),
    .rst      (rst),
    .load     (sp_load),
    .load_val (sp_val),
    .inc      (sp_inc),
    .dec      (sp_dec),
    .sp       (sp_w)
  );

  stk_rd_collect #(.DW(DW)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .vld   (rd_vld_q),
    .rdata (mem_rdata),
    .word  (rd_word)
  );

  // Memory port decoded from the registered sequencer state.
  always_comb begin
    mem_we   = 1'b0;
    mem_re   = 1'b0;
    mem_addr = '0;
    unique case (st_q)
      ST_WR: begin
        mem_we   = 1'b1;
        mem_addr = sp_w;
      end
      ST_RD: begin
        mem_re   = 1'b1;
        mem_addr = sp_w + AW'(1);
      end
      ST_VEC: begin
        mem_re   = 1'b1;
        mem_addr = VEC_ADDR + AW'(vec_idx_q);
      end
      default: ;
    endcase
  end
  assign mem_wdata = q_head;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_NOP;
      rd_left_q   <= '0;
      vec_idx_q   <= 1'b0;
      pc_q        <= '0;
      pc_tgt_q    <= '0;
      ccr_snap_q  <= '0;
      ccr_q       <= '0;
      pull_byte_q <= '0;
      pull_word_q <= '0;
      xfer_q      <= '0;
      done_q      <= 1'b0;
      rd_vld_q    <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      rd_vld_q <= mem_re;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            op_q <= op_in;
            unique case (op_in)
              OP_PUSH_B, OP_PUSH_W: st_q <= ST_WR;
              OP_CALL: begin
                st_q     <= ST_WR;
                pc_tgt_q <= imm;
              end
              OP_BCALL: begin
                st_q     <= ST_WR;
                pc_tgt_q <= ret_addr + disp_ext;
              end
              OP_SWI: begin
                st_q       <= ST_WR;
                ccr_snap_q <= ccr_in;
              end
              OP_PULL_B: begin
                st_q      <= ST_RD;
                rd_left_q <= 2'd1;
              end
              OP_PULL_W, OP_RET: begin
                st_q      <= ST_RD;
                rd_left_q <= 2'd2;
              end
              OP_SP2IDX: begin
                xfer_q <= sp_w + AW'(1);
                done_q <= 1'b1;
              end
              OP_JUMP: begin
                pc_q   <= imm;
                done_q <= 1'b1;
              end
              default: done_q <= 1'b1;
            endcase
          end
        end
        ST_WR: begin
          if (q_last) begin
            if (op_q == OP_SWI) begin
              st_q      <= ST_VEC;
              vec_idx_q <= 1'b0;
            end else begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              if ((op_q == OP_CALL) || (op_q == OP_BCALL)) pc_q <= pc_tgt_q;
            end
          end
        end
        ST_RD: begin
          rd_left_q <= rd_left_q - 2'd1;
          if (rd_left_q == 2'd1) st_q <= ST_CAP;
        end
        ST_VEC: begin
          vec_idx_q <= 1'b1;
          if (vec_idx_q) st_q <= ST_CAP;
        end
        ST_CAP: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          unique case (op_q)
            OP_PULL_B: pull_byte_q <= mem_rdata;
            OP_PULL_W: pull_word_q <= rd_word;
            OP_RET:    pc_q        <= rd_word;
            OP_SWI: begin
              pc_q  <= rd_word;
              ccr_q <= ccr_snap_q | MASK_VEC;
            end
            default: ;
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign sp        = sp_w;
  assign pc        = pc_q;
  assign pull_byte = pull_byte_q;
  assign pull_word = pull_word_q;
  assign xfer_word = xfer_q;
  assign ccr_out   = ccr_q;

  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r12_no_double_access: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  a_r10_mask_set: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_CAP) && (op_q == OP_SWI)) |=> ccr_out[MASK_BIT]);

  a_r7_call_target: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_WR) && q_last && (op_q == OP_CALL)) |=> (pc == $past(imm, 1) || pc == $past(pc_tgt_q)));

  a_r6_sp_to_idx: assert property (@(posedge clk) disable iff (rst)
    (accept && (op_in == OP_SP2IDX)) |=> (xfer_word == AW'($past(sp_w) + AW'(1))));

  a_r1_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

endmodule

// File: tb/tb_stk_call_seq.sv
module tb_stk_call_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] imm = '0;
  logic [7:0]  disp = '0;
  logic [7:0]  push_byte = '0;
  logic [15:0] idx_x = '0, idx_y = '0;
  logic [7:0]  acc_a = '0, acc_b = '0, ccr_in = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic        busy, done;
  logic [15:0] sp, pc, pull_word, xfer_word;
  logic [7:0]  pull_byte, ccr_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [23:0] exp_q[$];
  logic [7:0]  tmem [256];

  always #4 clk = ~clk;

  stk_call_seq dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .imm(imm), .disp(disp),
    .push_byte(push_byte), .idx_x(idx_x), .idx_y(idx_y), .acc_a(acc_a),
    .acc_b(acc_b), .ccr_in(ccr_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .sp(sp), .pc(pc),
    .pull_byte(pull_byte), .pull_word(pull_word), .xfer_word(xfer_word),
    .ccr_out(ccr_out)
  );

  // Synchronous byte memory, low eight address bits decoded.
  always @(posedge clk) begin
    if (mem_we) tmem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= tmem[mem_addr[7:0]];
  end

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expw(input logic [15:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  // Scoreboard monitor: every write is popped and compared.
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 unexpected write actual=%0h expected=none", {mem_addr, mem_wdata});
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if ({mem_addr, mem_wdata} !== e) begin
          n_fail++;
          $display("FAIL R4 write actual=%0h expected=%0h", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic run_op(input logic [3:0] o, input logic [15:0] im,
                        input logic [7:0] ds, input logic [7:0] pb,
                        input int exp_lat, input string req);
    int lat;
    @(negedge clk);
    op = o; imm = im; disp = ds; push_byte = pb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    eq({req, " R12 latency"}, lat, exp_lat);
    @(negedge clk);
    eq("R12 done pulse width", done, 1'b0);
    eq("R12 drained", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    tmem[8'hF6] = 8'h8A;
    tmem[8'hF7] = 8'h3C;
    repeat (3) @(negedge clk);
    eq("R1 reset sp", sp, 16'h0000);
    eq("R1 reset pc", pc, 16'h0000);
    eq("R1 reset busy", busy, 1'b0);
    eq("R12 reset done", done, 1'b0);
    eq("R10 reset ccr_out", ccr_out, 8'h00);
    rst = 1'b0;

    // R6 load SP
    run_op(4'd11, 16'h01F0, 8'h00, 8'h00, 0, "R6");
    eq("R6 load sp", sp, 16'h01F0);

    // R2 byte push
    expw(16'h01F0, 8'hA5);
    run_op(4'd1, 16'h0000, 8'h00, 8'hA5, 1, "R2");
    eq("R2 sp after push", sp, 16'h01EF);

    // R4 word push, low byte first
    expw(16'h01EF, 8'h34);
    expw(16'h01EE, 8'h12);
    run_op(4'd3, 16'h1234, 8'h00, 8'h00, 2, "R4");
    eq("R4 sp after push", sp, 16'h01ED);

    // R5 word pull, high byte first
    run_op(4'd4, 16'h0000, 8'h00, 8'h00, 3, "R5");
    eq("R5 pull_word", pull_word, 16'h1234);
    eq("R5 sp after pull", sp, 16'h01EF);

    // R3 byte pull
    run_op(4'd2, 16'h0000, 8'h00, 8'h00, 2, "R3");
    eq("R3 pull_byte", pull_byte, 8'hA5);
    eq("R3 sp after pull", sp, 16'h01F0);

    // R6 transfers
    run_op(4'd9, 16'h0000, 8'h00, 8'h00, 0, "R6");
    eq("R6 sp to index", xfer_word, 16'h01F1);
    idx_x = 16'h0300;
    run_op(4'd10, 16'h0000, 8'h00, 8'h00, 0, "R6");
    eq("R6 index to sp", sp, 16'h02FF);
    run_op(4'd11, 16'h01F0, 8'h00, 8'h00, 0, "R6");
    run_op(4'd12, 16'h4000, 8'h00, 8'h00, 0, "R6");
    eq("R6 load pc", pc, 16'h4000);

    // R7 call
    expw(16'h01F0, 8'h00);
    expw(16'h01EF, 8'h40);
    run_op(4'd5, 16'h5000, 8'h00, 8'h00, 2, "R7");
    eq("R7 pc target", pc, 16'h5000);
    eq("R7 sp", sp, 16'h01EE);

    // R8 relative call with negative displacement
    expw(16'h01EE, 8'h02);
    expw(16'h01ED, 8'h50);
    run_op(4'd6, 16'h0000, 8'hF0, 8'h00, 2, "R8");
    eq("R8 pc", pc, 16'h4FF2);
    eq("R8 sp", sp, 16'h01EC);

    // R9 returns
    run_op(4'd7, 16'h0000, 8'h00, 8'h00, 3, "R9");
    eq("R9 pc first return", pc, 16'h5002);
    run_op(4'd7, 16'h0000, 8'h00, 8'h00, 3, "R9");
    eq("R9 pc second return", pc, 16'h4000);
    eq("R9 sp", sp, 16'h01F0);

    // R10 software interrupt, mask clear on entry
    idx_x = 16'hCAFE; idx_y = 16'hBEEF; acc_a = 8'h11; acc_b = 8'h22; ccr_in = 8'h05;
    expw(16'h01F0, 8'h00); expw(16'h01EF, 8'h40);
    expw(16'h01EE, 8'hEF); expw(16'h01ED, 8'hBE);
    expw(16'h01EC, 8'hFE); expw(16'h01EB, 8'hCA);
    expw(16'h01EA, 8'h11); expw(16'h01E9, 8'h22); expw(16'h01E8, 8'h05);
    run_op(4'd8, 16'h0000, 8'h00, 8'h00, 12, "R10");
    eq("R10 vector pc", pc, 16'h8A3C);
    eq("R10 ccr mask", ccr_out, 8'h15);
    eq("R10 sp", sp, 16'h01E7);

    // R10 software interrupt with mask already set still runs
    ccr_in = 8'h10;
    expw(16'h01E7, 8'h3C); expw(16'h01E6, 8'h8A);
    expw(16'h01E5, 8'hEF); expw(16'h01E4, 8'hBE);
    expw(16'h01E3, 8'hFE); expw(16'h01E2, 8'hCA);
    expw(16'h01E1, 8'h11); expw(16'h01E0, 8'h22); expw(16'h01DF, 8'h10);
    run_op(4'd8, 16'h0000, 8'h00, 8'h00, 12, "R10");
    eq("R10 masked entry pc", pc, 16'h8A3C);
    eq("R10 masked ccr", ccr_out, 8'h10);
    eq("R10 masked sp", sp, 16'h01DE);

    // R11 wrap across the top of the map
    run_op(4'd11, 16'h0000, 8'h00, 8'h00, 0, "R11");
    expw(16'h0000, 8'hAD);
    expw(16'hFFFF, 8'hBE);
    run_op(4'd3, 16'hBEAD, 8'h00, 8'h00, 2, "R11");
    eq("R11 sp wrapped down", sp, 16'hFFFE);
    run_op(4'd4, 16'h0000, 8'h00, 8'h00, 3, "R11");
    eq("R11 pull across wrap", pull_word, 16'hBEAD);
    eq("R11 sp wrapped up", sp, 16'h0000);

    // R1 start while busy is ignored
    run_op(4'd11, 16'h0100, 8'h00, 8'h00, 0, "R1");
    expw(16'h0100, 8'h88);
    expw(16'h00FF, 8'h77);
    @(negedge clk);
    op = 4'd3; imm = 16'h7788; start = 1'b1;
    @(negedge clk);
    eq("R1 busy during push", busy, 1'b1);
    op = 4'd1; push_byte = 8'h99;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    eq("R1 sp ignores busy start", sp, 16'h00FE);
    eq("R1 idle after", busy, 1'b0);
    eq("R1 no extra write", exp_q.size(), 0);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule